// File: doc/BRIEF.md
# DMA Channel Cell and Block Start Sequencer

This block is the start control of one DMA channel. A block transfer is made of a programmed number of cells, each one data beat. The sequencer decides when each cell may begin and offers it to the datapath. It also tracks how many cells have finished and reports the end of the block. A start comes either from a software strobe or from one external event line. A select value picks that line. A value of zero, or one above the implemented range, leaves software as the only source.

A mode bit sets the start policy. In per-cell mode every cell waits for its own start. In per-block mode only the first cell waits, and the rest of the block follows with no further starts. The datapath side is a valid/ready pair. A cell is offered by holding `cell_valid` high. It is taken on the cycle where `cell_ready` is also high. Until then the offer stays up, so the datapath may apply back-pressure for as long as it needs. A taken cell reports completion with a one-cycle `cell_done`. A start that arrives while a cell is offered or running is kept as pending and is not lost. Dropping the channel enable abandons the block at once. The block also holds the channel priority and clamps a write that exceeds the highest implemented level.

Top module: `dma_cell_sequencer`

## Requirements
- R1: After reset `cell_valid` and `blk_done` are 0 and `prio_level` is 0.
- R2: With `trig_sel` = 0 no `ext_trig` line can start a cell, while a `sw_start` pulse raises `cell_valid` on the next cycle.
- R3: With `trig_sel` = s and 1 <= s <= TRIG_MAX, a pulse on `ext_trig[s-1]` starts a cell. Pulses on every other `ext_trig` line have no effect.
- R4: With `trig_sel` > TRIG_MAX every `ext_trig` line is ignored, and `sw_start` still starts a cell.
- R5: With `auto_blk` = 0, a cell that completes without a pending start leaves `cell_valid` low until a new start arrives.
- R6: With `auto_blk` = 1, one start launches the whole block. Each following cell is offered on the cycle after the previous `cell_done`. No cell is offered after the last one.
- R7: `cell_valid` stays high while `cell_ready` is low and falls on the cycle after the handshake.
- R8: A start received while a cell is offered or running is kept as pending. In per-cell mode the next cell is then offered on the cycle after `cell_done`.
- R9: The `cell_done` of the last cell of a block raises `blk_done` for exactly one cycle, starting on the next cycle. The cell count then restarts for the next block.
- R10: While `chan_en` is 0, `cell_valid` and `blk_done` fall on the next cycle and starts and `cell_done` are ignored. Any pending start is discarded and the cell count restarts.
- R11: A priority write stores min(`prio_wdata`, PRIO_MAX), seen on `prio_level` on the next cycle. Without a write `prio_level` holds its value.
- R12: A `cell_count` of 0 is treated as a block of one cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; 0 aborts and holds the sequencer idle |
| auto_blk | input | 1 | 1: one start per block; 0: one start per cell |
| trig_sel | input | SEL_W | External start select; 0 or above TRIG_MAX means software only |
| sw_start | input | 1 | Software start strobe, one pulse per start |
| ext_trig | input | TRIG_MAX | External start pulses; select s uses bit s-1 |
| cell_count | input | CNT_W | Cells per block (0 counts as 1) |
| cell_valid | output | 1 | A cell is offered to the datapath |
| cell_ready | input | 1 | Datapath accepts the offered cell |
| cell_done | input | 1 | One-cycle pulse: the accepted cell has finished |
| blk_done | output | 1 | One-cycle pulse: the block has finished |
| prio_we | input | 1 | Priority write strobe |
| prio_wdata | input | PRIO_W | Requested priority level |
| prio_level | output | PRIO_W | Stored, clamped priority level |

## Verification
A start, whether from the strobe or the selected line, shows as `cell_valid` one cycle after the edge that samples it. A handshake clears the offer one cycle later. A `cell_done` yields either the next offer or `blk_done` one cycle later, and a priority write shows one cycle later. The bench drives inputs on the falling edge and checks outputs on the falling edge after the edge that should change them. A scoreboard monitor samples just before each rising edge and matches every handshake and block-done pulse, in order, against the items the driver queued. Stimulus that must have no effect is followed by a check that the offer is still low.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_ARM   = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_BUSY  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dma_trig_select.sv
module dma_trig_select #(
  parameter int SEL_W    = 8,
  parameter int TRIG_MAX = 23
) (
  input  logic [SEL_W-1:0]    trig_sel,
  input  logic                sw_start,
  input  logic [TRIG_MAX-1:0] ext_trig,
  output logic                start_hit
);
  logic [TRIG_MAX-1:0] line_hit;

  // One comparator per implemented line; any other select value matches none.
  genvar gi;
  generate
    for (gi = 0; gi < TRIG_MAX; gi++) begin : g_line
      assign line_hit[gi] = ext_trig[gi] && (trig_sel == SEL_W'(gi + 1));
    end
  endgenerate

  assign start_hit = sw_start | (|line_hit);
endmodule

// File: rtl/dma_cell_fsm.sv
module dma_cell_fsm
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             auto_blk,
  input  logic             start_hit,
  input  logic [CNT_W-1:0] cell_count,
  input  logic             cell_ready,
  input  logic             cell_done,
  output logic             cell_valid,
  output logic             blk_done
);
  seq_state_t       state;
  logic             pend;
  logic [CNT_W-1:0] done_cnt;
  logic [CNT_W-1:0] cnt_eff;
  logic             last_cell;

  assign cnt_eff    = (cell_count == '0) ? CNT_W'(1) : cell_count;
  assign last_cell  = (done_cnt == cnt_eff - CNT_W'(1));
  assign cell_valid = (state == SEQ_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_ARM;
      pend     <= 1'b0;
      done_cnt <= '0;
      blk_done <= 1'b0;
    end else if (!chan_en) begin
      state    <= SEQ_ARM;
      pend     <= 1'b0;
      done_cnt <= '0;
      blk_done <= 1'b0;
    end else begin
      blk_done <= 1'b0;
      case (state)
        SEQ_ARM: begin
          if (pend || start_hit) begin
            state <= SEQ_ISSUE;
            pend  <= 1'b0;
          end
        end
        SEQ_ISSUE: begin
          if (cell_ready) state <= SEQ_BUSY;
          if (start_hit) pend <= 1'b1;
        end
        SEQ_BUSY: begin
          if (cell_done) begin
            if (last_cell) begin
              done_cnt <= '0;
              blk_done <= 1'b1;
              state    <= SEQ_ARM;
              if (start_hit) pend <= 1'b1;
            end else begin
              done_cnt <= done_cnt + CNT_W'(1);
              if (auto_blk) begin
                state <= SEQ_ISSUE;
                if (start_hit) pend <= 1'b1;
              end else if (pend || start_hit) begin
                state <= SEQ_ISSUE;
                pend  <= 1'b0;
              end else begin
                state <= SEQ_ARM;
              end
            end
          end else if (start_hit) begin
            pend <= 1'b1;
          end
        end
        default: state <= SEQ_ARM;
      endcase
    end
  end
endmodule

// File: rtl/dma_prio_clamp.sv
module dma_prio_clamp #(
  parameter int PRIO_W   = 2,
  parameter int PRIO_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_wdata,
  output logic [PRIO_W-1:0] prio_level
);
  localparam logic [PRIO_W-1:0] LvlTop = PRIO_W'(PRIO_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_level <= '0;
    else if (prio_we) prio_level <= (prio_wdata > LvlTop) ? LvlTop : prio_wdata;
  end
endmodule

// File: rtl/dma_cell_sequencer.sv
module dma_cell_sequencer #(
  parameter int SEL_W    = 8,
  parameter int TRIG_MAX = 23,
  parameter int CNT_W    = 8,
  parameter int PRIO_W   = 2,
  parameter int PRIO_MAX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chan_en,
  input  logic                auto_blk,
  input  logic [SEL_W-1:0]    trig_sel,
  input  logic                sw_start,
  input  logic [TRIG_MAX-1:0] ext_trig,
  input  logic [CNT_W-1:0]    cell_count,
  output logic                cell_valid,
  input  logic                cell_ready,
  input  logic                cell_done,
  output logic                blk_done,
  input  logic                prio_we,
  input  logic [PRIO_W-1:0]   prio_wdata,
  output logic [PRIO_W-1:0]   prio_level
);
  logic start_hit;

  dma_trig_select #(.SEL_W(SEL_W), .TRIG_MAX(TRIG_MAX)) u_sel (
    .trig_sel  (trig_sel),
    .sw_start  (sw_start),
    .ext_trig  (ext_trig),
    .start_hit (start_hit)
  );

  dma_cell_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .auto_blk   (auto_blk),
    .start_hit  (start_hit),
    .cell_count (cell_count),
    .cell_ready (cell_ready),
    .cell_done  (cell_done),
    .cell_valid (cell_valid),
    .blk_done   (blk_done)
  );

  dma_prio_clamp #(.PRIO_W(PRIO_W), .PRIO_MAX(PRIO_MAX)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .prio_we    (prio_we),
    .prio_wdata (prio_wdata),
    .prio_level (prio_level)
  );
endmodule

// File: rtl/dma_cell_sequencer_chk.sv
module dma_cell_sequencer_chk #(
  parameter int PRIO_W   = 2,
  parameter int PRIO_MAX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              cell_valid,
  input logic              cell_ready,
  input logic              blk_done,
  input logic              prio_we,
  input logic [PRIO_W-1:0] prio_level
);
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && cell_valid && !cell_ready) |=> cell_valid);

  p_valid_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && cell_valid && cell_ready) |=> !cell_valid);

  p_blk_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!cell_valid && !blk_done));

  p_prio_ceiling_r11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(prio_level) <= PRIO_MAX);

  p_prio_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_we |=> $stable(prio_level));
endmodule

bind dma_cell_sequencer dma_cell_sequencer_chk #(.PRIO_W(PRIO_W), .PRIO_MAX(PRIO_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_en    (chan_en),
  .cell_valid (cell_valid),
  .cell_ready (cell_ready),
  .blk_done   (blk_done),
  .prio_we    (prio_we),
  .prio_level (prio_level)
);

// File: tb/dma_cell_sequencer_tb.sv
module dma_cell_sequencer_tb;
  localparam int SEL_W    = 8;
  localparam int TRIG_MAX = 23;
  localparam int CNT_W    = 8;
  localparam int PRIO_W   = 2;
  localparam int PRIO_MAX = 2;
  localparam int K_CELL   = 0;
  localparam int K_BLK    = 1;

  typedef struct {
    int    kind;
    string req;
  } sb_item_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                chan_en = 1'b0;
  logic                auto_blk = 1'b0;
  logic [SEL_W-1:0]    trig_sel = '0;
  logic                sw_start = 1'b0;
  logic [TRIG_MAX-1:0] ext_trig = '0;
  logic [CNT_W-1:0]    cell_count = '0;
  logic                cell_valid;
  logic                cell_ready = 1'b1;
  logic                cell_done = 1'b0;
  logic                blk_done;
  logic                prio_we = 1'b0;
  logic [PRIO_W-1:0]   prio_wdata = '0;
  logic [PRIO_W-1:0]   prio_level;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  sb_item_t exp_q[$];

  always #5 clk = ~clk;

  dma_cell_sequencer #(
    .SEL_W(SEL_W), .TRIG_MAX(TRIG_MAX), .CNT_W(CNT_W),
    .PRIO_W(PRIO_W), .PRIO_MAX(PRIO_MAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .auto_blk(auto_blk),
    .trig_sel(trig_sel), .sw_start(sw_start), .ext_trig(ext_trig),
    .cell_count(cell_count), .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_done(cell_done), .blk_done(blk_done), .prio_we(prio_we),
    .prio_wdata(prio_wdata), .prio_level(prio_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input string req);
    sb_item_t it;
    it.kind = kind;
    it.req  = req;
    exp_q.push_back(it);
  endtask

  task automatic sb_take(input int kind);
    sb_item_t it;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard unexpected event actual %0d expected none", kind);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != kind) begin
        errors++;
        $display("FAIL %s event kind actual %0d expected %0d", it.req, kind, it.kind);
      end
    end
  endtask

  // Monitor: samples just before each rising edge.
  always begin
    @(negedge clk);
    #4;
    if (rst_n) begin
      if (cell_valid && cell_ready) sb_take(K_CELL);
      if (blk_done) sb_take(K_BLK);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic sw_pulse();
    sw_start = 1'b1;
    cyc();
    sw_start = 1'b0;
  endtask

  task automatic done_pulse();
    cell_done = 1'b1;
    cyc();
    cell_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk(cell_valid == 1'b0, "R1 cell_valid", int'(cell_valid), 0);
    chk(blk_done == 1'b0, "R1 blk_done", int'(blk_done), 0);
    chk(prio_level == '0, "R1 prio_level", int'(prio_level), 0);
    rst_n = 1'b1;
    cyc();

    // R11 priority clamp
    prio_we = 1'b1; prio_wdata = 2'd3;
    cyc();
    prio_we = 1'b0;
    chk(prio_level == 2'd2, "R11 clamp", int'(prio_level), 2);
    prio_wdata = 2'd0;
    cyc();
    chk(prio_level == 2'd2, "R11 hold", int'(prio_level), 2);
    prio_we = 1'b1; prio_wdata = 2'd1;
    cyc();
    prio_we = 1'b0;
    chk(prio_level == 2'd1, "R11 in range", int'(prio_level), 1);

    // R2 select 0: software only
    chan_en = 1'b1; trig_sel = 8'd0; cell_count = 8'd2; auto_blk = 1'b0;
    cyc();
    ext_trig = '1;
    cyc();
    ext_trig = '0;
    chk(!cell_valid, "R2 ext ignored", int'(cell_valid), 0);
    expect_ev(K_CELL, "R2");
    sw_pulse();
    chk(cell_valid, "R2 sw start", int'(cell_valid), 1);
    cyc();
    chk(!cell_valid, "R7 taken", int'(cell_valid), 0);
    done_pulse();
    chk(!cell_valid, "R5 waits after cell", int'(cell_valid), 0);
    cyc(); cyc();
    chk(!cell_valid, "R5 still waiting", int'(cell_valid), 0);
    chk(!blk_done, "R9 not yet", int'(blk_done), 0);
    expect_ev(K_CELL, "R5");
    sw_pulse();
    chk(cell_valid, "R5 second start", int'(cell_valid), 1);
    cyc();
    expect_ev(K_BLK, "R9");
    done_pulse();
    chk(blk_done, "R9 block done", int'(blk_done), 1);
    cyc();
    chk(!blk_done, "R9 one cycle", int'(blk_done), 0);

    // R3 in-range select
    cell_count = 8'd1; trig_sel = 8'd5;
    ext_trig = '1; ext_trig[4] = 1'b0;
    cyc();
    ext_trig = '0;
    chk(!cell_valid, "R3 other lines ignored", int'(cell_valid), 0);
    expect_ev(K_CELL, "R3");
    ext_trig[4] = 1'b1;
    cyc();
    ext_trig = '0;
    chk(cell_valid, "R3 selected line", int'(cell_valid), 1);
    cyc();
    expect_ev(K_BLK, "R3");
    done_pulse();
    chk(blk_done, "R3 block done", int'(blk_done), 1);
    cyc();

    // R4 out-of-range select
    trig_sel = 8'(TRIG_MAX + 1);
    ext_trig = '1;
    cyc();
    ext_trig = '0;
    chk(!cell_valid, "R4 above max", int'(cell_valid), 0);
    trig_sel = 8'hFF;
    ext_trig = '1;
    cyc();
    ext_trig = '0;
    chk(!cell_valid, "R4 at 255", int'(cell_valid), 0);
    expect_ev(K_CELL, "R4");
    sw_pulse();
    chk(cell_valid, "R4 sw start", int'(cell_valid), 1);
    cyc();
    expect_ev(K_BLK, "R4");
    done_pulse();
    cyc();

    // R6 auto block
    trig_sel = 8'd0; auto_blk = 1'b1; cell_count = 8'd3;
    expect_ev(K_CELL, "R6"); expect_ev(K_CELL, "R6"); expect_ev(K_CELL, "R6");
    expect_ev(K_BLK, "R6");
    sw_pulse();
    chk(cell_valid, "R6 first", int'(cell_valid), 1);
    cyc();
    done_pulse();
    chk(cell_valid, "R6 second auto", int'(cell_valid), 1);
    cyc();
    done_pulse();
    chk(cell_valid, "R6 third auto", int'(cell_valid), 1);
    cyc();
    done_pulse();
    chk(blk_done, "R6 block done", int'(blk_done), 1);
    chk(!cell_valid, "R6 no extra cell", int'(cell_valid), 0);
    cyc();
    chk(!cell_valid, "R6 stays idle", int'(cell_valid), 0);
    auto_blk = 1'b0;

    // R7 back-pressure
    cell_count = 8'd1; cell_ready = 1'b0;
    expect_ev(K_CELL, "R7"); expect_ev(K_BLK, "R7");
    sw_pulse();
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(cell_valid, "R7 held", int'(cell_valid), 1);
    end
    cell_ready = 1'b1;
    cyc();
    chk(!cell_valid, "R7 released", int'(cell_valid), 0);
    done_pulse();
    chk(blk_done, "R7 block done", int'(blk_done), 1);
    cyc();

    // R8 pending start
    cell_count = 8'd2;
    expect_ev(K_CELL, "R8");
    sw_pulse();
    cyc();
    chk(!cell_valid, "R8 busy", int'(cell_valid), 0);
    expect_ev(K_CELL, "R8");
    sw_pulse();
    chk(!cell_valid, "R8 latched not issued", int'(cell_valid), 0);
    done_pulse();
    chk(cell_valid, "R8 pending used", int'(cell_valid), 1);
    cyc();
    expect_ev(K_BLK, "R8");
    done_pulse();
    chk(blk_done, "R8 block done", int'(blk_done), 1);
    cyc();

    // R10 abort
    expect_ev(K_CELL, "R10");
    sw_pulse();
    cyc();
    done_pulse();
    expect_ev(K_CELL, "R10");
    sw_pulse();
    cyc();
    sw_pulse();
    chan_en = 1'b0;
    cyc();
    chk(!cell_valid, "R10 abort", int'(cell_valid), 0);
    sw_pulse();
    done_pulse();
    chan_en = 1'b1;
    cyc(); cyc();
    chk(!cell_valid, "R10 pending discarded", int'(cell_valid), 0);
    chk(!blk_done, "R10 no block done", int'(blk_done), 0);
    expect_ev(K_CELL, "R10");
    sw_pulse();
    cyc();
    done_pulse();
    chk(!blk_done, "R10 count restarted", int'(blk_done), 0);
    expect_ev(K_CELL, "R10");
    sw_pulse();
    cyc();
    expect_ev(K_BLK, "R10");
    done_pulse();
    chk(blk_done, "R10 full block", int'(blk_done), 1);
    cyc();

    // R12 zero count
    cell_count = 8'd0;
    expect_ev(K_CELL, "R12"); expect_ev(K_BLK, "R12");
    sw_pulse();
    cyc();
    done_pulse();
    chk(blk_done, "R12 zero is one", int'(blk_done), 1);
    cyc(); cyc();

    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule